// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block drives one pulse-width-modulated pin. A power-of-two prescaler turns the system clock into count ticks. A period counter steps once per tick and returns to zero after it reaches a programmed limit. Two programmed counts inside that period mark where the pin enters and leaves its active phase. The active phase and the inactive phase each carry their own 2-bit drive code, which sets the pin level during that phase.

Software loads two shadow words: a window word and a timing word. Each has its own single-cycle write strobe, and a strobe is accepted on every cycle it is high, so the block applies no back-pressure. Writing the timing word, or pulsing the commit input, arms a transfer. An armed transfer copies both shadow words into the working configuration. While the channel is enabled the copy waits for the counter to wrap, so a period never mixes old and new settings. While the channel is disabled the copy happens at once. The window word must be written before the timing word.

Top module: `pwm_shadow_chan`

## Requirements
- R1: After reset the pin is low and the working configuration is all zero, so enabling the channel before any transfer keeps the pin low.
- R2: While enabled, the counter takes the values 0 through P, where P is the timing word bits 15:0. It advances one step per prescaled tick, so a period lasts P+1 ticks. With P=0 every tick starts a new period.
- R3: Let S be the window word bits 15:0 and D the window word bits 31:16. The pin is in its active phase while S <= count < D and in its inactive phase otherwise. When S >= D the active phase never occurs.
- R4: The active-phase drive code is the timing word bits 17:16 and the inactive-phase drive code is bits 19:18. Code 3 drives the pin high. Code 2 drives it low, and so do codes 0 and 1.
- R5: The timing word bits 22:20 select the prescale. Codes 0 through 7 give one tick every 1, 2, 4, 8, 16, 64, 256 and 1024 clocks.
- R6: Writing only the window word changes nothing on the pin until a transfer is armed.
- R7: While enabled, an armed transfer takes effect at the next counter wrap, not at the moment of the write.
- R8: A commit pulse arms a transfer of the current shadow words, just as a timing-word write does.
- R9: While disabled, the counter and prescaler are held at zero, an armed transfer completes on the next clock, and the pin shows the inactive-phase drive level.
- R10: The pin is registered. On the first clock edge with enable high, the pin takes the level for count 0, and the new period starts from count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel run control |
| act_wr | input | 1 | Write strobe for the window shadow word |
| act_data | input | 32 | Window word: duty count in bits 31:16, start count in bits 15:0 |
| per_wr | input | 1 | Write strobe for the timing shadow word; arms a transfer |
| per_data | input | 23 | Timing word: prescale code in bits 22:20, inactive drive code in bits 19:18, active drive code in bits 17:16, period in bits 15:0 |
| commit | input | 1 | Pulse that arms a transfer without a new timing word |
| pwm_out | output | 1 | Registered pin level |

## Verification
The assertions check, on every cycle, the rules that hold in any state. The count never exceeds the working period and advances by one on each tick that does not wrap. The counter and the prescaler are held at zero while disabled. An armed transfer clears at a wrap, or at once when disabled. A write to the window word alone leaves the working configuration unchanged. The pin shows the inactive level after a disabled cycle. Only the bench scenarios can show the waveform itself: the high-time count over whole periods for each prescale code, both drive polarities, the inert codes, an empty window, and the one-tick period. They also show that a mid-period update keeps the old duty until the wrap, and that the first level after enabling belongs to count 0.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int CNT_W   = 16;
  localparam int DRV_W   = 2;
  localparam int DIV_W   = 3;
  localparam int SHIFT_W = DIV_W + 1;
  localparam int PRE_W   = 2 * ((1 << DIV_W) - 1) - 4;

  localparam int PER_LSB   = 0;
  localparam int ADRV_LSB  = PER_LSB + CNT_W;
  localparam int IDRV_LSB  = ADRV_LSB + DRV_W;
  localparam int DIV_LSB   = IDRV_LSB + DRV_W;
  localparam int PER_W     = DIV_LSB + DIV_W;
  localparam int START_LSB = 0;
  localparam int DUTY_LSB  = START_LSB + CNT_W;
  localparam int ACT_W     = DUTY_LSB + CNT_W;

  localparam logic [DRV_W-1:0] DRV_HIGH = 2'b11;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [DRV_W-1:0] idle_drv;
    logic [DRV_W-1:0] act_drv;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] start;
    logic [CNT_W-1:0] duty;
  } pwm_cfg_t;

  // Prescale shift: linear up to code 4, then steps of two.
  function automatic logic [SHIFT_W-1:0] div_shift(logic [DIV_W-1:0] code);
    if (code <= DIV_W'(4)) return {1'b0, code};
    else return {code, 1'b0} - SHIFT_W'(4);
  endfunction

  function automatic logic drive_level(logic [DRV_W-1:0] code);
    return (code == DRV_HIGH);
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_shadow_pkg::*;
#(
  parameter int P_W = PRE_W,
  parameter int S_W = SHIFT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [S_W-1:0] shift,
  output logic           tick
);
  logic [P_W-1:0] pcnt;
  logic [P_W-1:0] lim;

  assign lim  = ~({P_W{1'b1}} << shift);
  assign tick = run && (pcnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt <= '0;
    else if (!run || tick)   pcnt <= '0;
    else                     pcnt <= pcnt + 1'b1;
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= lim); // R5
  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pcnt == '0); // R9
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_shadow_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             act_wr,
  input  logic [ACT_W-1:0] act_data,
  input  logic             per_wr,
  input  logic [PER_W-1:0] per_data,
  input  logic             commit,
  input  logic             wrap,
  output pwm_cfg_t         work
);
  logic [ACT_W-1:0] act_sh;
  logic [PER_W-1:0] per_sh;
  logic             armed;
  logic             xfer;
  pwm_cfg_t         staged;

  assign xfer = armed && (wrap || !enable);

  always_comb begin
    staged.div      = per_sh[DIV_LSB  +: DIV_W];
    staged.idle_drv = per_sh[IDRV_LSB +: DRV_W];
    staged.act_drv  = per_sh[ADRV_LSB +: DRV_W];
    staged.period   = per_sh[PER_LSB  +: CNT_W];
    staged.start    = act_sh[START_LSB +: CNT_W];
    staged.duty     = act_sh[DUTY_LSB  +: CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sh <= '0;
      per_sh <= '0;
      armed  <= 1'b0;
      work   <= '0;
    end else begin
      if (act_wr) act_sh <= act_data;
      if (per_wr) per_sh <= per_data;
      if (per_wr || commit) armed <= 1'b1;
      else if (xfer)        armed <= 1'b0;
      if (xfer) work <= staged;
    end
  end

  AST_SHADOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (act_wr && !armed && !per_wr && !commit) |=> $stable(work)); // R6
  AST_ARM_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wrap && enable && !per_wr && !commit) |=> !armed); // R7
  AST_ARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !enable && !per_wr && !commit) |=> !armed); // R9
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
  import pwm_shadow_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     tick,
  input  pwm_cfg_t cfg,
  output logic     wrap,
  output logic     level
);
  logic [CNT_W-1:0] cnt;
  logic             in_win;
  logic             nxt_level;

  assign wrap   = tick && (cnt >= cfg.period);
  assign in_win = (cnt >= cfg.start) && (cnt < cfg.duty);

  always_comb begin
    if (enable && in_win) nxt_level = drive_level(cfg.act_drv);
    else                  nxt_level = drive_level(cfg.idle_drv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      level <= 1'b0;
    end else begin
      level <= nxt_level;
      if (!enable)   cnt <= '0;
      else if (wrap) cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cfg.period); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && !wrap) |=> cnt == $past(cnt) + 1'b1); // R2
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> cnt == '0); // R9
endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
  import pwm_shadow_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             act_wr,
  input  logic [ACT_W-1:0] act_data,
  input  logic             per_wr,
  input  logic [PER_W-1:0] per_data,
  input  logic             commit,
  output logic             pwm_out
);
  pwm_cfg_t work;
  logic     tick;
  logic     wrap;

  pwm_shadow_regs u_regs (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .act_wr(act_wr), .act_data(act_data),
    .per_wr(per_wr), .per_data(per_data),
    .commit(commit), .wrap(wrap), .work(work)
  );

  pwm_prescaler #(.P_W(PRE_W), .S_W(SHIFT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(enable),
    .shift(div_shift(work.div)), .tick(tick)
  );

  pwm_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .cfg(work), .wrap(wrap), .level(pwm_out)
  );

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> pwm_out == ($past(work.idle_drv) == DRV_HIGH)); // R9
endmodule

// File: tb/pwm_shadow_chan_bench.sv
`timescale 1ns/1ps
module pwm_shadow_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        act_wr = 1'b0;
  logic [31:0] act_data = '0;
  logic        per_wr = 1'b0;
  logic [22:0] per_data = '0;
  logic        commit = 1'b0;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  string tag_q[$];
  int    exp_q[$];
  int    act_q[$];
  event  res_ev;

  always #2.5 clk = ~clk;

  pwm_shadow_chan u_pwm_shadow_chan (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .act_wr(act_wr), .act_data(act_data),
    .per_wr(per_wr), .per_data(per_data),
    .commit(commit), .pwm_out(pwm_out)
  );

  function automatic logic [22:0] tword(int p, int a, int i, int d);
    return {3'(d), 2'(i), 2'(a), 16'(p)};
  endfunction

  function automatic logic [31:0] wword(int s, int d);
    return {16'(d), 16'(s)};
  endfunction

  task automatic drain();
    while (act_q.size() > 0) begin
      string t = tag_q.pop_front();
      int    e = exp_q.pop_front();
      int    a = act_q.pop_front();
      checks++;
      if (a != e) begin
        errors++;
        $display("FAIL %s actual %0d expected %0d", t, a, e);
      end
    end
  endtask

  initial forever begin
    @(res_ev);
    drain();
  end

  // Driver side: expected value goes in, the observed value follows.
  task automatic check(string t, int e, int a);
    tag_q.push_back(t);
    exp_q.push_back(e);
    act_q.push_back(a);
    -> res_ev;
  endtask

  task automatic measure(int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
  endtask

  task automatic write_cfg(logic [31:0] w, logic [22:0] t);
    @(negedge clk); act_wr = 1'b1; act_data = w;
    @(negedge clk); act_wr = 1'b0; per_wr = 1'b1; per_data = t;
    @(negedge clk); per_wr = 1'b0;
  endtask

  task automatic idle_cfg(logic [31:0] w, logic [22:0] t);
    @(negedge clk); enable = 1'b0;
    write_cfg(w, t);
    repeat (2) @(negedge clk);
  endtask

  task automatic start();
    enable = 1'b1;
  endtask

  task automatic summary();
    drain();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      summary();
    end
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset level", 0, int'(pwm_out));
    start();
    measure(10, hi);
    check("R1 default config inert", 0, hi);

    // R9: transfer while disabled is immediate, pin shows inactive level
    idle_cfg(wword(2, 5), tword(9, 2, 3, 0));
    check("R9 idle level high", 1, int'(pwm_out));
    measure(20, hi);
    check("R9 counter held while idle", 20, hi);

    // R4: inverse polarity, active low for counts 2..4
    @(negedge clk); start();
    measure(40, hi);
    check("R4 inverse drive", 28, hi);

    // R3: normal polarity
    idle_cfg(wword(2, 5), tword(9, 3, 2, 0));
    check("R9 idle level low", 0, int'(pwm_out));
    start();
    measure(40, hi);
    check("R3 active window", 12, hi);

    // R6: window word alone changes nothing
    @(negedge clk); act_wr = 1'b1; act_data = wword(0, 8);
    @(negedge clk); act_wr = 1'b0;
    measure(40, hi);
    check("R6 shadow write held", 12, hi);

    // R8: commit pulse applies the shadow
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    repeat (15) @(negedge clk);
    measure(40, hi);
    check("R8 commit applies", 32, hi);

    // R5: prescale codes
    idle_cfg(wword(2, 5), tword(9, 3, 2, 1));
    start();
    measure(80, hi);
    check("R5 prescale code 1", 24, hi);
    idle_cfg(wword(0, 1), tword(1, 3, 2, 5));
    start();
    measure(256, hi);
    check("R5 prescale code 5", 128, hi);

    // R2: period length
    idle_cfg(wword(0, 1), tword(0, 3, 2, 0));
    start();
    measure(20, hi);
    check("R2 zero period", 20, hi);
    idle_cfg(wword(0, 3), tword(4, 3, 2, 0));
    start();
    measure(40, hi);
    check("R2 period of five", 24, hi);

    // R7: mid-period update waits for the wrap
    idle_cfg(wword(0, 50), tword(99, 3, 2, 0));
    start();
    repeat (20) @(negedge clk);
    write_cfg(wword(0, 10), tword(99, 3, 2, 0));
    repeat (5) @(negedge clk);
    check("R7 old duty kept", 1, int'(pwm_out));
    repeat (150) @(negedge clk);
    measure(100, hi);
    check("R7 new duty after wrap", 10, hi);

    // R3: empty window
    idle_cfg(wword(6, 6), tword(9, 3, 2, 0));
    start();
    measure(40, hi);
    check("R3 start equals duty", 0, hi);

    // R4: inert codes drive low
    idle_cfg(wword(0, 5), tword(9, 1, 3, 0));
    start();
    measure(40, hi);
    check("R4 active code 1 low", 20, hi);
    idle_cfg(wword(0, 5), tword(9, 3, 0, 0));
    start();
    measure(40, hi);
    check("R4 idle code 0 low", 20, hi);

    // R10: restart from count 0, one register of latency
    idle_cfg(wword(0, 1), tword(9, 3, 2, 0));
    check("R10 before enable", 0, int'(pwm_out));
    start();
    @(negedge clk);
    check("R10 first level is count 0", 1, int'(pwm_out));
    @(negedge clk);
    check("R10 second level is count 1", 0, int'(pwm_out));
    repeat (4) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R9 disable drops to idle", 0, int'(pwm_out));
    start();
    @(negedge clk);
    check("R10 restart at count 0", 1, int'(pwm_out));

    done = 1'b1;
    summary();
  end
endmodule